// File: doc/BRIEF.md
# Gated Event Counter with Routed Overflow Interrupt

This block counts single-cycle event pulses in a 48-bit register. An event is counted only when two enables agree: an enable bit in a small local control register and a start bit in a global control register. This lets software arm a counter locally and then start or stop many counters at once from one global place. At most one event is counted per clock cycle.

Software can write any value into the counter. In sampling use, it writes a value close to the top of the range so that the counter wraps after a chosen number of events. The wrap from all ones to zero sets a sticky overflow status bit. While that bit is set and the local interrupt enable is set, the block drives a level interrupt to every core whose bit is set in a routing mask in the global control register. All registers can be read back through a registered read port.

Register selection uses a 2-bit code: 0 is local control, 1 is global control, 2 is the counter, and 3 is status.

Top module: `gated_event_counter`

## Requirements
- R1: After a synchronous reset, the counter, both control registers, the overflow status, `irq_o` and `rd_data_o` are all zero.
- R2: While local control bit 0 (the local enable, select 0) is clear, event pulses leave the counter unchanged, even when the global start bit is set.
- R3: While global control bit 0 (the start bit, select 1) is clear, event pulses leave the counter unchanged. When both enables are set, each cycle with `evt_i` high adds exactly one to the counter, and `count_o` shows the result one cycle later.
- R4: A write to select 2 loads `wr_data_i[47:0]` into the counter. If an event is counted in the same cycle, the load wins and the event is lost.
- R5: An increment from all ones to zero sets the overflow status bit (select 3, bit 0). The bit stays set until a write to select 3 with data bit 0 set. A write with data bit 0 clear has no effect on it. A new overflow in the same cycle as a clear leaves the bit set.
- R6: After a preload of 2^48 − N, the Nth counted event wraps the counter to zero and sets the overflow status bit.
- R7: `irq_o[k]` is high exactly when, in the previous cycle, the overflow status bit, local control bit 2 (interrupt enable) and global control bit 1+k (the routing bit for core k) were all set.
- R8: While the interrupt enable is clear, `irq_o` stays all zero, whatever the overflow status is.
- R9: `rd_data_o` shows, one cycle after `rd_sel_i` is presented, the register chosen by that select. Local control appears at bits 0 and 2, global control at bit 0 and bits NUM_CORES:1, the counter at bits 47:0, and status at bit 0. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 1 | Event pulse, at most one count per cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write register select (0 local, 1 global, 2 counter, 3 status) |
| wr_data_i | input | DATA_W | Write data |
| rd_sel_i | input | 2 | Read register select, same coding as writes |
| rd_data_o | output | DATA_W | Registered read data |
| count_o | output | CNT_W | Current counter value |
| irq_o | output | NUM_CORES | Per-core level interrupt request |

## Verification
The assertions assume that `evt_i` and the write strobe are clean single-bit levels sampled once per cycle. They also assume that at most one register write arrives per cycle. This means a status clear can only meet an overflow caused by an event, never one caused by a second write. The stimulus drives every input once per cycle on the falling edge through a single task, so each cycle carries exactly one optional write and one optional event. Random counter loads are biased to values a few counts below all ones, so that wraps, sticky status and the clear-versus-overflow collision happen often rather than never.

// File: rtl/gec_pkg.sv
package gec_pkg;
  typedef enum logic [1:0] {
    SEL_LOCAL  = 2'd0,
    SEL_GLOBAL = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  localparam int LOC_EN_BIT    = 0;
  localparam int LOC_IE_BIT    = 2;
  localparam int GLB_START_BIT = 0;
  localparam int GLB_MASK_LSB  = 1;
  localparam int STS_OVF_BIT   = 0;
endpackage

// File: rtl/gec_ctrl_regs.sv
module gec_ctrl_regs #(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 loc_we_i,
  input  logic                 glb_we_i,
  input  logic                 en_d_i,
  input  logic                 ie_d_i,
  input  logic                 start_d_i,
  input  logic [NUM_CORES-1:0] mask_d_i,
  output logic                 loc_en_o,
  output logic                 loc_ie_o,
  output logic                 glb_start_o,
  output logic [NUM_CORES-1:0] glb_mask_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      loc_en_o    <= 1'b0;
      loc_ie_o    <= 1'b0;
      glb_start_o <= 1'b0;
      glb_mask_o  <= '0;
    end else begin
      if (loc_we_i) begin
        loc_en_o <= en_d_i;
        loc_ie_o <= ie_d_i;
      end
      if (glb_we_i) begin
        glb_start_o <= start_d_i;
        glb_mask_o  <= mask_d_i;
      end
    end
  end
endmodule

// File: rtl/gec_counter.sv
module gec_counter #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_i,
  input  logic             cnt_en_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic bump;
  logic wrap;

  assign bump = evt_i && cnt_en_i && !ld_i;
  assign wrap = bump && (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (ld_i)
        cnt_q <= ld_val_i;
      else if (bump)
        cnt_q <= cnt_q + ONE;
      if (wrap)
        ovf_q <= 1'b1;
      else if (ovf_clr_i)
        ovf_q <= 1'b0;
    end
  end

  // R2
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(evt_i && cnt_en_i) && !ld_i) |=> (cnt_q == $past(cnt_q)));
  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_i && cnt_en_i && !ld_i) |=> (cnt_q == $past(cnt_q) + ONE));
  // R4
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ld_i |=> (cnt_q == $past(ld_val_i)));
  // R5
  wrap_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_i && cnt_en_i && !ld_i && (cnt_q == '1)) |=> (ovf_q && cnt_q == '0));
  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !ovf_clr_i) |=> ovf_q);
endmodule

// File: rtl/gec_irq_fanout.sv
module gec_irq_fanout #(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ovf_i,
  input  logic                 ie_i,
  input  logic [NUM_CORES-1:0] mask_i,
  output logic [NUM_CORES-1:0] irq_q
);
  logic fire;
  assign fire = ovf_i && ie_i;

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
    always_ff @(posedge clk) begin
      if (rst) irq_q[k] <= 1'b0;
      else     irq_q[k] <= fire && mask_i[k];
    end
  end

  // R8
  ie_off_chk: assert property (@(posedge clk) disable iff (rst)
    !ie_i |=> (irq_q == '0));
  // R7
  no_ovf_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ovf_i |=> (irq_q == '0));
  // R7
  route_subset_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_q & ~$past(mask_i)) == '0));
endmodule

// File: rtl/gated_event_counter.sv
module gated_event_counter
  import gec_pkg::*;
#(
  parameter int CNT_W     = 48,
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 evt_i,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_sel_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [1:0]           rd_sel_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic [CNT_W-1:0]     count_o,
  output logic [NUM_CORES-1:0] irq_o
);
  localparam int MASK_MSB = GLB_MASK_LSB + NUM_CORES - 1;

  reg_sel_e wsel, rsel;
  logic loc_en, loc_ie, glb_start, ovf;
  logic [NUM_CORES-1:0] glb_mask;
  logic [CNT_W-1:0] cnt;
  logic [DATA_W-1:0] rd_next;

  assign wsel = reg_sel_e'(wr_sel_i);
  assign rsel = reg_sel_e'(rd_sel_i);

  gec_ctrl_regs #(.NUM_CORES(NUM_CORES)) u_regs (
    .clk(clk), .rst(rst),
    .loc_we_i(wr_en_i && wsel == SEL_LOCAL),
    .glb_we_i(wr_en_i && wsel == SEL_GLOBAL),
    .en_d_i(wr_data_i[LOC_EN_BIT]),
    .ie_d_i(wr_data_i[LOC_IE_BIT]),
    .start_d_i(wr_data_i[GLB_START_BIT]),
    .mask_d_i(wr_data_i[MASK_MSB:GLB_MASK_LSB]),
    .loc_en_o(loc_en), .loc_ie_o(loc_ie),
    .glb_start_o(glb_start), .glb_mask_o(glb_mask)
  );

  gec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .evt_i(evt_i),
    .cnt_en_i(loc_en && glb_start),
    .ld_i(wr_en_i && wsel == SEL_COUNT),
    .ld_val_i(wr_data_i[CNT_W-1:0]),
    .ovf_clr_i(wr_en_i && wsel == SEL_STATUS && wr_data_i[STS_OVF_BIT]),
    .cnt_q(cnt), .ovf_q(ovf)
  );

  gec_irq_fanout #(.NUM_CORES(NUM_CORES)) u_irq (
    .clk(clk), .rst(rst),
    .ovf_i(ovf), .ie_i(loc_ie), .mask_i(glb_mask),
    .irq_q(irq_o)
  );

  generate
    if (DATA_W > CNT_W) begin : g_unused
      logic unused_hi;
      assign unused_hi = ^wr_data_i[DATA_W-1:CNT_W];
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    unique case (rsel)
      SEL_LOCAL: begin
        rd_next[LOC_EN_BIT] = loc_en;
        rd_next[LOC_IE_BIT] = loc_ie;
      end
      SEL_GLOBAL: begin
        rd_next[GLB_START_BIT]          = glb_start;
        rd_next[MASK_MSB:GLB_MASK_LSB] = glb_mask;
      end
      SEL_COUNT:  rd_next[CNT_W-1:0]  = cnt;
      SEL_STATUS: rd_next[STS_OVF_BIT] = ovf;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_next;
  end

  assign count_o = cnt;

  // R9
  rd_count_chk: assert property (@(posedge clk) disable iff (rst)
    (rsel == SEL_COUNT) |=> (rd_data_o[CNT_W-1:0] == $past(count_o)));
  // R9
  rd_status_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsel == SEL_STATUS) |=> (rd_data_o[DATA_W-1:1] == '0));
endmodule

// File: tb/gated_event_counter_test.sv
module gated_event_counter_test;
  localparam int CW = 48;
  localparam int NC = 4;
  localparam int DW = 64;
  localparam logic [CW-1:0] ALL1 = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evt_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [1:0] rd_sel_i = '0;
  logic [DW-1:0] rd_data_o;
  logic [CW-1:0] count_o;
  logic [NC-1:0] irq_o;

  int vectors = 0;
  int miscompares = 0;

  // model state
  logic [CW-1:0] m_cnt = '0;
  logic m_en = 0, m_ie = 0, m_start = 0, m_ovf = 0;
  logic [NC-1:0] m_mask = '0;
  logic [NC-1:0] e_irq = '0;
  logic [DW-1:0] e_rd = '0;

  always #5 clk = ~clk;

  gated_event_counter #(.CNT_W(CW), .NUM_CORES(NC), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .count_o(count_o), .irq_o(irq_o)
  );

  function automatic logic [DW-1:0] read_model(input logic [1:0] sel);
    logic [DW-1:0] v = '0;
    case (sel)
      2'd0: begin v[0] = m_en; v[2] = m_ie; end
      2'd1: begin v[0] = m_start; v[NC:1] = m_mask; end
      2'd2: v[CW-1:0] = m_cnt;
      default: v[0] = m_ovf;
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic evt, input logic we,
                     input logic [1:0] wa, input logic [DW-1:0] wd, input logic [1:0] ra);
    logic inc, ld, wrap, clr;
    evt_i = evt; wr_en_i = we; wr_sel_i = wa; wr_data_i = wd; rd_sel_i = ra;
    e_irq = (m_ovf && m_ie) ? m_mask : '0;
    e_rd  = read_model(ra);
    ld   = we && wa == 2'd2;
    inc  = evt && m_en && m_start && !ld;
    wrap = inc && (m_cnt == ALL1);
    clr  = we && wa == 2'd3 && wd[0];
    if (ld) m_cnt = wd[CW-1:0];
    else if (inc) m_cnt = m_cnt + 1'b1;
    if (wrap) m_ovf = 1'b1;
    else if (clr) m_ovf = 1'b0;
    if (we && wa == 2'd0) begin m_en = wd[0]; m_ie = wd[2]; end
    if (we && wa == 2'd1) begin m_start = wd[0]; m_mask = wd[NC:1]; end
    @(negedge clk);
    check({tag, " count"}, DW'(count_o), DW'(m_cnt));
    check({tag, " irq R7"}, DW'(irq_o), DW'(e_irq));
    check({tag, " read R9"}, rd_data_o, e_rd);
  endtask

  task automatic idle(input string tag, input logic [1:0] ra);
    cyc(tag, 1'b0, 1'b0, 2'd0, '0, ra);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog all requirements: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 count", DW'(count_o), '0);
    check("R1 irq", DW'(irq_o), '0);
    check("R1 read", rd_data_o, '0);
    for (int s = 0; s < 4; s++) idle("R1", 2'(s));

    // R2 global start set, local enable clear
    cyc("R2", 1'b0, 1'b1, 2'd1, 64'h1, 2'd1);
    for (int i = 0; i < 5; i++) cyc("R2", 1'b1, 1'b0, 2'd0, '0, 2'd2);
    check("R2 held", DW'(count_o), '0);

    // R3 local enable set, start clear
    cyc("R3", 1'b0, 1'b1, 2'd1, 64'h0, 2'd0);
    cyc("R3", 1'b0, 1'b1, 2'd0, 64'h1, 2'd0);
    for (int i = 0; i < 4; i++) cyc("R3", 1'b1, 1'b0, 2'd0, '0, 2'd2);
    check("R3 held", DW'(count_o), '0);
    cyc("R3", 1'b0, 1'b1, 2'd1, 64'h1, 2'd1);
    for (int i = 0; i < 4; i++) cyc("R3", 1'b1, 1'b0, 2'd0, '0, 2'd2);
    check("R3 counted", DW'(count_o), 64'd4);

    // R4 load beats event
    cyc("R4", 1'b1, 1'b1, 2'd2, 64'h1234_5678_9ABC, 2'd2);
    check("R4 load", DW'(count_o), 64'h1234_5678_9ABC);

    // R6 preload 2^48-3, wrap on third event
    cyc("R6", 1'b0, 1'b1, 2'd2, DW'(ALL1 - 48'd2), 2'd3);
    cyc("R6", 1'b1, 1'b0, 2'd0, '0, 2'd3);
    cyc("R6", 1'b1, 1'b0, 2'd0, '0, 2'd3);
    check("R6 not yet", DW'(count_o), DW'(ALL1));
    cyc("R6", 1'b1, 1'b0, 2'd0, '0, 2'd3);
    check("R6 wrap", DW'(count_o), '0);
    idle("R6", 2'd3);
    check("R6 status", rd_data_o, 64'h1);

    // R7 route to cores 0 and 2
    cyc("R7", 1'b0, 1'b1, 2'd1, 64'h1 | (64'b0101 << 1), 2'd1);
    cyc("R7", 1'b0, 1'b1, 2'd0, 64'h5, 2'd0);
    idle("R7", 2'd0);
    check("R7 routed", DW'(irq_o), 64'h5);
    // R8 interrupt enable cleared
    cyc("R8", 1'b0, 1'b1, 2'd0, 64'h1, 2'd0);
    idle("R8", 2'd3);
    check("R8 quiet", DW'(irq_o), '0);

    // R5 clear with bit0 clear has no effect; set wins over clear
    cyc("R5", 1'b0, 1'b1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFE, 2'd3);
    idle("R5", 2'd3);
    check("R5 kept", rd_data_o, 64'h1);
    cyc("R5", 1'b0, 1'b1, 2'd2, DW'(ALL1), 2'd3);
    cyc("R5", 1'b1, 1'b1, 2'd3, 64'h1, 2'd3);
    idle("R5", 2'd3);
    check("R5 set wins", rd_data_o, 64'h1);
    cyc("R5", 1'b0, 1'b1, 2'd3, 64'h1, 2'd3);
    idle("R5", 2'd3);
    check("R5 cleared", rd_data_o, 64'h0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] wa = 2'($urandom_range(0, 3));
      logic [DW-1:0] wd = {$urandom(), $urandom()};
      if (wa == 2'd2 && $urandom_range(0, 1) == 1)
        wd = DW'(ALL1 - 48'($urandom_range(0, 7)));
      if (wa != 2'd2 && $urandom_range(0, 3) != 0) wd[0] = 1'b1;
      cyc("R3 R4 R5", $urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0,
          wa, wd, 2'($urandom_range(0, 3)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule